// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator and Tap Modulator

This block is the digital control half of a frequency-locked loop. It runs on the clock of a multi-tap digitally controlled oscillator and steers that oscillator. It does this by comparing the oscillator's rate with a slow reference signal. The oscillator clock first passes through a pre-divider with a factor of 1, 2, 4 or 8. It then passes through a second counter that divides by the multiplier value plus one. Each completed feedback period lowers a 10-bit frequency integrator by one. Each rising edge of the reference raises it by one. The reference is an asynchronous input and is resynchronised before it is used.

The integrator value is split into a coarse part and a fine part. The upper five bits choose a base oscillator tap. Only 29 taps exist, so any code above 28 is treated as tap 28. The lower five bits give a blend value. Over every 32 oscillator cycles, the block selects the next tap up for exactly that many cycles and the base tap for the rest. The higher-tap cycles are spread as evenly as possible. A configuration bit turns the blending off.

Configuration fields are latched together on a write strobe: the pre-divider code, the multiplier, the delivered-clock pre-divider bypass, the blend disable, and a range code that is passed straight to the oscillator. The integrator value is available as an output.

Top module: `fll_core`

## Requirements
- R1: After reset, the integrator reads 0 and the tap output reads 0. The configuration takes these values: pre-divider code 01 (divide by 2), multiplier 127, bypass clear, blending enabled, range code 0.
- R2: The pre-divider code maps 00, 01, 10 and 11 to factors 1, 2, 4 and 8. With bypass clear, `clk_en_out` pulses once every D cycles. With bypass set, it is high on every cycle.
- R3: With no reference edges and the integrator above 0, the integrator drops by one exactly once every D*(N+1) oscillator cycles. N is the multiplier field. The pre-divider is always part of the feedback path.
- R4: Each rising edge of `ref_clk` raises the integrator by one. A rise driven before clock edge k shows in `integ_val` after clock edge k+2.
- R5: When an increase and a decrease fall in the same cycle, the integrator keeps its value.
- R6: The integrator saturates. It holds at 1023 instead of wrapping up, and holds at 0 instead of wrapping down.
- R7: The base tap is `integ_val[9:5]` limited to 28. `tap_sel` is always the base tap or the base tap plus one.
- R8: With blending enabled, the base tap below 28 and the integrator steady, any 32 consecutive values of `tap_sel` hold base+1 exactly `integ_val[4:0]` times. When that count is 16 or less, no two base+1 cycles are adjacent.
- R9: When the base tap is 28, `tap_sel` stays at 28 and never exceeds 28.
- R10: With the blend-disable bit set, `tap_sel` equals the base tap on every cycle.
- R11: A cycle with `cfg_we` high loads every configuration field. `dco_range` shows the loaded range code from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Asynchronous low-frequency reference |
| cfg_we | input | 1 | Load strobe for all configuration fields |
| cfg_div_sel | input | 2 | Pre-divider code (00=/1, 01=/2, 10=/4, 11=/8) |
| cfg_mult | input | 7 | Multiplier N; the feedback divides by N+1 |
| cfg_no_prediv | input | 1 | Delivered clock undivided when set |
| cfg_mod_off | input | 1 | Disables tap blending when set |
| cfg_range | input | 4 | Oscillator range code |
| integ_val | output | 10 | Frequency integrator value |
| tap_sel | output | 5 | Oscillator tap for this cycle |
| dco_range | output | 4 | Latched range code |
| clk_en_out | output | 1 | Delivered clock enable (oscillator/D, or every cycle) |

## Verification
A table drives seven combinations of pre-divider code, multiplier and bypass. For each one, the bench times the gap between successive integrator decrements and counts the delivered enables. This separates a wrong divide order, a wrong D encoding and an off-by-one in N+1. Dense bursts of reference edges against a very slow feedback check the exact synchronizer latency and the ceiling. A fast feedback with no edges checks the floor. Edges added on top of a fast feedback at the floor check the cancellation of simultaneous events. Blend windows of 32 cycles are taken at mid-range values, with blending turned off, and at the top tap. These show whether the high-tap count follows the fine bits, whether the blend disable and the 28 cap hold, and whether high cycles are kept apart.

// File: rtl/fll_pkg.sv
package fll_pkg;

   // Pre-divider factor for a given selection code (powers of two).
   function automatic int prediv_factor(input int sel);
      return 1 << sel;
   endfunction

   // Width of the blend window counter and the number of cycles in one window.
   function automatic int window_cycles(input int frac_bits);
      return 1 << frac_bits;
   endfunction

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fll_ref_sync: at least two synchronizer stages are required");
   end

   // Stages 0..STAGES-1 resynchronise; the last element is the edge-detect delay.
   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], ref_in};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R4: one reference edge never yields two consecutive up events
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/fll_fb_divider.sv
module fll_fb_divider import fll_pkg::*; #(
   parameter int DSEL_W = 2,
   parameter int N_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DSEL_W-1:0] div_sel,
   input  logic [N_W-1:0]    mult,
   output logic              pd_tick,
   output logic              fb_tick
);
   localparam int PC_W = (1 << DSEL_W) - 1;

   if (DSEL_W < 1 || DSEL_W > 3) begin : g_bad_dsel
      $error("fll_fb_divider: DSEL_W must be 1 to 3");
   end
   if (N_W < 1) begin : g_bad_n
      $error("fll_fb_divider: N_W must be positive");
   end

   logic [PC_W-1:0] pd_cnt;
   logic [PC_W-1:0] pd_lim;
   logic [N_W-1:0]  n_cnt;
   logic            n_wrap;

   assign pd_lim  = PC_W'(prediv_factor(int'(div_sel)) - 1);
   assign pd_tick = (pd_cnt >= pd_lim);
   assign n_wrap  = (n_cnt >= mult);
   assign fb_tick = pd_tick & n_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pd_cnt <= '0;
      end else if (pd_tick) begin
         pd_cnt <= '0;
      end else begin
         pd_cnt <= pd_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_cnt <= '0;
      end else if (pd_tick) begin
         n_cnt <= n_wrap ? '0 : n_cnt + 1'b1;
      end
   end

   // R2: with a divide factor above one and a steady code, ticks are never back to back
   a_r2_prediv_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_tick && div_sel != '0 && $stable(div_sel)) |=> !pd_tick);

   // R3: with N above zero and steady settings, feedback events never come on adjacent cycles
   a_r3_fb_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_tick && mult != '0 && $stable(mult)) |=> !fb_tick);

endmodule

// File: rtl/fll_integrator.sv
module fll_integrator #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] TOP_VAL = '1;

   if (W < 2) begin : g_bad_w
      $error("fll_integrator: W must be at least 2");
   end

   logic inc_ok;
   logic dec_ok;

   assign inc_ok = up & ~dn & (value != TOP_VAL);
   assign dec_ok = dn & ~up & (value != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      value <= '0;
      else if (inc_ok) value <= value + 1'b1;
      else if (dec_ok) value <= value - 1'b1;
   end

   // R5: coincident up and down events leave the value unchanged
   a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (up && dn) |=> $stable(value));

   // R6: an up event at the ceiling does not wrap
   a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (value == TOP_VAL && up && !dn) |=> (value == TOP_VAL));

   // R6: a down event at the floor does not wrap
   a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (value == '0 && dn && !up) |=> (value == '0));

   // R4: the value only ever moves by a single step
   a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (value != $past(value)) |->
         (value == $past(value) + 1'b1 || value == $past(value) - 1'b1));

endmodule

// File: rtl/fll_tap_modulator.sv
module fll_tap_modulator #(
   parameter int INTEG_W   = 10,
   parameter int FRAC_W    = 5,
   parameter int TAP_COUNT = 29,
   parameter int TAP_W     = INTEG_W - FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INTEG_W-1:0] integ,
   input  logic               mod_off,
   output logic [TAP_W-1:0]   tap_q
);
   localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(TAP_COUNT - 1);

   if (TAP_W + FRAC_W != INTEG_W) begin : g_bad_split
      $error("fll_tap_modulator: coarse and fine widths must fill the integrator");
   end
   if (TAP_COUNT < 2 || TAP_COUNT > (1 << TAP_W)) begin : g_bad_taps
      $error("fll_tap_modulator: TAP_COUNT out of range for the coarse field");
   end

   logic [TAP_W-1:0]  coarse;
   logic [FRAC_W-1:0] frac;
   logic [TAP_W-1:0]  base;
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   sum;
   logic              step_up;

   assign coarse = integ[INTEG_W-1 -: TAP_W];
   assign frac   = integ[FRAC_W-1:0];

   // Clamp only when the coarse field can address codes beyond the last tap.
   if (TAP_COUNT < (1 << TAP_W)) begin : g_clamp
      assign base = (coarse > TOP_TAP) ? TOP_TAP : coarse;
   end else begin : g_direct
      assign base = coarse;
   end

   // Fractional accumulator: the carry marks the cycles that take the higher tap.
   assign sum     = {1'b0, acc} + {1'b0, frac};
   assign step_up = sum[FRAC_W] & ~mod_off & (base != TOP_TAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         tap_q <= '0;
      end else begin
         acc   <= sum[FRAC_W-1:0];
         tap_q <= base + TAP_W'(step_up);
      end
   end

   // R9: the selected tap never goes beyond the last physical tap
   a_r9_tap_cap: assert property (@(posedge clk) disable iff (!rst_n)
      tap_q <= TOP_TAP);

   // R10: with blending disabled the base tap is used unchanged
   a_r10_mod_off: assert property (@(posedge clk) disable iff (!rst_n)
      mod_off |=> (tap_q == $past(base)));

   // R7: the output is the base tap or one above it
   a_r7_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tap_q == $past(base) || tap_q == $past(base) + 1'b1));

endmodule

// File: rtl/fll_core.sv
module fll_core #(
   parameter int INTEG_W     = 10,
   parameter int FRAC_W      = 5,
   parameter int TAP_COUNT   = 29,
   parameter int N_W         = 7,
   parameter int DSEL_W      = 2,
   parameter int RANGE_W     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RST_DSEL    = 1,
   parameter int RST_MULT    = 127
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ref_clk,
   input  logic                       cfg_we,
   input  logic [DSEL_W-1:0]          cfg_div_sel,
   input  logic [N_W-1:0]             cfg_mult,
   input  logic                       cfg_no_prediv,
   input  logic                       cfg_mod_off,
   input  logic [RANGE_W-1:0]         cfg_range,
   output logic [INTEG_W-1:0]         integ_val,
   output logic [INTEG_W-FRAC_W-1:0]  tap_sel,
   output logic [RANGE_W-1:0]         dco_range,
   output logic                       clk_en_out
);
   localparam int TAP_W = INTEG_W - FRAC_W;

   if (RST_DSEL < 0 || RST_DSEL >= (1 << DSEL_W)) begin : g_bad_rst_dsel
      $error("fll_core: RST_DSEL does not fit the pre-divider code");
   end
   if (RST_MULT < 0 || RST_MULT >= (1 << N_W)) begin : g_bad_rst_mult
      $error("fll_core: RST_MULT does not fit the multiplier field");
   end

   logic [DSEL_W-1:0]  div_sel_q;
   logic [N_W-1:0]     mult_q;
   logic               no_prediv_q;
   logic               mod_off_q;
   logic [RANGE_W-1:0] range_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_sel_q   <= DSEL_W'(RST_DSEL);
         mult_q      <= N_W'(RST_MULT);
         no_prediv_q <= 1'b0;
         mod_off_q   <= 1'b0;
         range_q     <= '0;
      end else if (cfg_we) begin
         div_sel_q   <= cfg_div_sel;
         mult_q      <= cfg_mult;
         no_prediv_q <= cfg_no_prediv;
         mod_off_q   <= cfg_mod_off;
         range_q     <= cfg_range;
      end
   end

   logic ref_rise;
   logic pd_tick;
   logic fb_tick;

   fll_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (ref_clk),
      .rise   (ref_rise)
   );

   fll_fb_divider #(.DSEL_W(DSEL_W), .N_W(N_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel_q),
      .mult    (mult_q),
      .pd_tick (pd_tick),
      .fb_tick (fb_tick)
   );

   fll_integrator #(.W(INTEG_W)) u_integ (
      .clk   (clk),
      .rst_n (rst_n),
      .up    (ref_rise),
      .dn    (fb_tick),
      .value (integ_val)
   );

   fll_tap_modulator #(
      .INTEG_W   (INTEG_W),
      .FRAC_W    (FRAC_W),
      .TAP_COUNT (TAP_COUNT),
      .TAP_W     (TAP_W)
   ) u_mod (
      .clk     (clk),
      .rst_n   (rst_n),
      .integ   (integ_val),
      .mod_off (mod_off_q),
      .tap_q   (tap_sel)
   );

   assign dco_range  = range_q;
   assign clk_en_out = no_prediv_q | pd_tick;

   // R11: a write strobe makes the range code visible on the next cycle
   a_r11_range_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (dco_range == $past(cfg_range)));

   // R2: with the bypass set the delivered enable is continuous
   a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      no_prediv_q |-> clk_en_out);

endmodule

// File: tb/fll_core_test.sv
module fll_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int TOP_TAP    = 28;

   // Stimulus table: {bypass, div code, multiplier, expected feedback period}
   localparam logic [20:0] VEC [0:6] = '{
      {1'b0, 2'd0, 7'd0,   11'd1},
      {1'b0, 2'd1, 7'd3,   11'd8},
      {1'b1, 2'd2, 7'd5,   11'd24},
      {1'b0, 2'd3, 7'd9,   11'd80},
      {1'b0, 2'd2, 7'd0,   11'd4},
      {1'b1, 2'd0, 7'd127, 11'd128},
      {1'b0, 2'd3, 7'd127, 11'd1024}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_div_sel = 2'd0;
   logic [6:0] cfg_mult = 7'd0;
   logic       cfg_no_prediv = 1'b0;
   logic       cfg_mod_off = 1'b0;
   logic [3:0] cfg_range = 4'd0;
   logic [9:0] integ_val;
   logic [4:0] tap_sel;
   logic [3:0] dco_range;
   logic       clk_en_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   fll_core uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_clk       (ref_clk),
      .cfg_we        (cfg_we),
      .cfg_div_sel   (cfg_div_sel),
      .cfg_mult      (cfg_mult),
      .cfg_no_prediv (cfg_no_prediv),
      .cfg_mod_off   (cfg_mod_off),
      .cfg_range     (cfg_range),
      .integ_val     (integ_val),
      .tap_sel       (tap_sel),
      .dco_range     (dco_range),
      .clk_en_out    (clk_en_out)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit mod_off_now = 1'b0;

   // Monitor for the saturation and cancellation phases
   bit track = 1'b0;
   int prev_v = 0;
   int max_v = 0;
   int jumps = 0;
   int nonzero = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (track) begin
         if (int'(integ_val) > prev_v + 1 || int'(integ_val) < prev_v - 1) jumps++;
         if (int'(integ_val) > max_v) max_v = int'(integ_val);
         if (integ_val != 10'd0) nonzero++;
         prev_v = int'(integ_val);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [1:0] d, input logic [6:0] n, input bit bp,
                            input bit mo, input logic [3:0] rg);
      cfg_div_sel   = d;
      cfg_mult      = n;
      cfg_no_prediv = bp;
      cfg_mod_off   = mo;
      cfg_range     = rg;
      cfg_we        = 1'b1;
      mod_off_now   = mo;
      step(1);
      cfg_we        = 1'b0;
   endtask

   task automatic pump(input int k);
      repeat (k) begin
         ref_clk = 1'b1;
         step(2);
         ref_clk = 1'b0;
         step(2);
      end
   endtask

   task automatic wait_change(output int cycles);
      int prev;
      prev = int'(integ_val);
      cycles = 0;
      do begin
         step(1);
         cycles++;
      end while (int'(integ_val) == prev && cycles < 3000);
   endtask

   task automatic count_enables(output int cnt);
      cnt = 0;
      repeat (64) begin
         step(1);
         cnt += int'(clk_en_out);
      end
   endtask

   // One 32-cycle blend window at a steady integrator value
   task automatic blend_window(input string req);
      int dummy;
      int v;
      int base;
      int hi;
      int bad;
      int adj;
      int exp_hi;
      bit last_hi;
      wait_change(dummy);
      step(3);
      v = int'(integ_val);
      base = ((v >> 5) > TOP_TAP) ? TOP_TAP : (v >> 5);
      exp_hi = (mod_off_now || base >= TOP_TAP) ? 0 : (v & 31);
      hi = 0; bad = 0; adj = 0; last_hi = 1'b0;
      for (int i = 0; i < 32; i++) begin
         step(1);
         if (int'(tap_sel) == base + 1 && base < TOP_TAP) begin
            hi++;
            if (last_hi) adj++;
            last_hi = 1'b1;
         end else begin
            if (int'(tap_sel) != base) bad++;
            last_hi = 1'b0;
         end
      end
      chk(int'(integ_val) == v, "R8 integrator steady in window", int'(integ_val), v);
      chk(bad == 0, "R7 tap is base or base+1", bad, 0);
      chk(hi == exp_hi, req, hi, exp_hi);
      if (exp_hi > 0 && exp_hi <= 16)
         chk(adj == 0, "R8 high cycles spread apart", adj, 0);
   endtask

   initial begin
      int cnt;
      int per;
      int dummy;
      int v;

      // R1: reset state
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(integ_val == 10'd0, "R1 integrator at reset", int'(integ_val), 0);
      chk(tap_sel == 5'd0, "R1 tap at reset", int'(tap_sel), 0);
      chk(dco_range == 4'd0, "R1 range at reset", int'(dco_range), 0);
      count_enables(cnt);
      chk(cnt == 32, "R1 R2 default divide by 2 delivered enable", cnt, 32);

      // R11: configuration load, slow feedback (8 * 128)
      write_cfg(2'd3, 7'd127, 1'b0, 1'b0, 4'hA);
      chk(dco_range == 4'hA, "R11 range code loaded", int'(dco_range), 10);

      // R4: exact synchronizer latency
      ref_clk = 1'b1;
      step(2);
      chk(integ_val == 10'd0, "R4 no change before third edge", int'(integ_val), 0);
      step(1);
      chk(integ_val == 10'd1, "R4 increment after third edge", int'(integ_val), 1);
      ref_clk = 1'b0;
      step(2);

      // R4: many edges accumulate (a few slow feedback events subtract)
      pump(710);
      v = int'(integ_val);
      chk(v >= 705 && v <= 711, "R4 accumulated reference edges", v, 708);

      // R8: blend at a mid-range value
      blend_window("R8 high-tap count equals fine bits");

      // R3 and R2: table of divider settings
      for (int k = 0; k < 7; k++) begin
         write_cfg(VEC[k][19:18], VEC[k][17:11], VEC[k][20], 1'b0, 4'h3);
         wait_change(dummy);
         wait_change(per);
         chk(per == int'(VEC[k][10:0]), "R3 feedback period D*(N+1)", per, int'(VEC[k][10:0]));
         count_enables(cnt);
         chk(cnt == (VEC[k][20] ? 64 : (64 >> VEC[k][19:18])), "R2 delivered enable rate",
             cnt, (VEC[k][20] ? 64 : (64 >> VEC[k][19:18])));
      end

      // R10: blending disabled, then enabled again
      write_cfg(2'd3, 7'd127, 1'b0, 1'b1, 4'h3);
      blend_window("R10 no high taps when blending is off");
      write_cfg(2'd3, 7'd127, 1'b0, 1'b0, 4'h3);
      blend_window("R8 high-tap count after re-enable");

      // R6: ceiling
      prev_v = int'(integ_val);
      max_v = 0;
      jumps = 0;
      track = 1'b1;
      pump(520);
      track = 1'b0;
      chk(max_v == 1023, "R6 ceiling reached", max_v, 1023);
      chk(jumps == 0, "R6 no wrap at ceiling", jumps, 0);
      v = int'(integ_val);
      chk(v >= 1018, "R6 value held near ceiling", v, 1023);

      // R9: top tap
      blend_window("R9 top tap never blended upward");

      // R6: floor with a feedback event on every cycle
      write_cfg(2'd0, 7'd0, 1'b0, 1'b0, 4'h3);
      step(1100);
      chk(integ_val == 10'd0, "R6 floor reached", int'(integ_val), 0);
      nonzero = 0;
      prev_v = 0;
      track = 1'b1;
      step(50);
      track = 1'b0;
      chk(nonzero == 0, "R6 no wrap at floor", nonzero, 0);

      // R5: reference edges coinciding with feedback events at the floor
      nonzero = 0;
      track = 1'b1;
      pump(20);
      step(4);
      track = 1'b0;
      chk(nonzero == 0, "R5 coincident events cancel", nonzero, 0);

      // R1: reset during operation restores the defaults
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      chk(integ_val == 10'd0, "R1 integrator after second reset", int'(integ_val), 0);
      chk(dco_range == 4'd0, "R1 range after second reset", int'(dco_range), 0);
      count_enables(cnt);
      chk(cnt == 32, "R1 default pre-divider after second reset", cnt, 32);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule